// File: doc/BRIEF.md
# Instruction Fetch Cycle Controller

This block steps a small processor datapath through the register transfers that bring one instruction out of memory. It holds a program counter, a memory address register, a memory data register and an instruction register. These sit around a word-addressed memory with a combinational read port. A four-state sequencer raises one load enable for each register and sets the select lines of the two input multiplexers. Every register then updates on the same clock edge as every other, so no clock is ever gated.

A fetch runs in three steps. First the address register takes the program counter. Next, the data register captures the addressed memory word while the program counter advances by one; both happen on the same edge. Last, the instruction register takes the data register. One placeholder execute cycle follows, and then the next fetch begins. Two external address inputs reach the second leg of each multiplexer: a jump target for the program counter and an operand address for the address register. Later execute states can use them, but no fetch step selects them. A synchronous write port fills the memory.

Top module: `fetch_unit`

## Requirements
- R1: While rst_n is low at a rising edge, the state becomes execute (code 0), all four registers become zero, and all four load enables are low.
- R2: The state codes are 0 execute, 1 address-load, 2 data-load, 3 instruction-load. Out of reset the state advances 0, 1, 2, 3, 0, 1 and so on, spending exactly one cycle in each state.
- R3: In state 1, ld_mar is the only load enable that is high, and mar_sel is 0. At the next edge the address register takes the program counter value.
- R4: In state 2, ld_mdr and ld_pc are high and the other two enables are low. pc_sel is 0. At the next edge the data register takes mem[MAR] and the program counter takes its old value plus one.
- R5: In state 3, ld_ir is the only load enable that is high. At the next edge the instruction register takes the data register value.
- R6: In state 0, no load enable is high, and all four registers keep their values.
- R7: The program counter wraps from 2**AW-1 to 0.
- R8: Select value 0 picks the internal source (PC for MAR, PC+1 for PC) and value 1 picks the external input. No fetch state selects 1, so branch_target and operand_addr have no effect on any register during fetch.
- R9: When mem_wr_en is high, mem_wr_data is written to mem_wr_addr at the rising edge. The read port shows mem[MAR] without any delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| branch_target | input | AW | External jump target, used when pc_sel is 1 |
| operand_addr | input | AW | External operand address, used when mar_sel is 1 |
| mem_wr_en | input | 1 | Memory write strobe |
| mem_wr_addr | input | AW | Memory write address |
| mem_wr_data | input | DW | Memory write word |
| state_o | output | 2 | Current sequencer state code |
| ld_mar_o | output | 1 | Address register load enable |
| ld_mdr_o | output | 1 | Data register load enable |
| ld_ir_o | output | 1 | Instruction register load enable |
| ld_pc_o | output | 1 | Program counter load enable |
| mar_sel_o | output | 1 | Address register input select |
| pc_sel_o | output | 1 | Program counter input select |
| pc_o | output | AW | Program counter |
| mar_o | output | AW | Memory address register |
| mdr_o | output | DW | Memory data register |
| ir_o | output | DW | Instruction register |

## Verification
The bench drives random values on both external address inputs for the whole run. A multiplexer whose select defaults to 1 would therefore show up as a wrong address or a wrong jump. It runs more fetches than the memory has words, so the program counter wraps. An incrementer that saturates or skips would fail the per-fetch check of IR against the preloaded word. A reset lands in the middle of a data-load step. It must leave state 0 and PC 0, and a design that finished the pending increment would not. A word rewritten during reset must then come back on the third fetch, which catches a read port that returns a stale word or a word from the wrong address.

// File: rtl/fetch_pkg.sv
// Shared definitions for the instruction fetch controller.
// Assumes a two-bit state code whose values are visible at the top ports.
package fetch_pkg;
    typedef enum logic [1:0] {
        ST_EXEC  = 2'd0,
        ST_LDMAR = 2'd1,
        ST_LDMDR = 2'd2,
        ST_LDIR  = 2'd3
    } fetch_state_t;

    localparam logic SEL_INTERNAL = 1'b0;
    localparam logic SEL_EXTERNAL = 1'b1;

    typedef struct packed {
        logic mar;
        logic mdr;
        logic ir;
        logic pc;
        logic mar_sel;
        logic pc_sel;
    } fetch_ctl_t;
endpackage

// File: rtl/fetch_seq.sv
// Fetch sequencer: a four-state machine plus the control decode for each state.
// Assumes one cycle per state and a synchronous active-low reset.
module fetch_seq
    import fetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    output fetch_state_t state,
    output fetch_ctl_t   ctl
);
    fetch_state_t state_nx;

    // Choose the successor state.
    always_comb begin
        unique case (state)
            ST_EXEC:  state_nx = ST_LDMAR;
            ST_LDMAR: state_nx = ST_LDMDR;
            ST_LDMDR: state_nx = ST_LDIR;
            default:  state_nx = ST_EXEC;
        endcase
    end

    // Hold the state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EXEC;
        else        state <= state_nx;
    end

    // Decode the load enables and selects; selects stay internal when not used.
    always_comb begin
        ctl         = '0;
        ctl.mar_sel = SEL_INTERNAL;
        ctl.pc_sel  = SEL_INTERNAL;
        unique case (state)
            ST_LDMAR: ctl.mar = 1'b1;
            ST_LDMDR: begin
                ctl.mdr = 1'b1;
                ctl.pc  = 1'b1;
            end
            ST_LDIR:  ctl.ir = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/fetch_datapath.sv
// Fetch datapath: PC, MAR, MDR and IR, the PC incrementer and two input muxes.
// Assumes the load enables are clock enables on a single clock.
module fetch_datapath
    import fetch_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fetch_ctl_t    ctl,
    input  logic [AW-1:0] branch_target,
    input  logic [AW-1:0] operand_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [AW-1:0] mar,
    output logic [DW-1:0] mdr,
    output logic [DW-1:0] ir
);
    logic [AW-1:0] pc_inc;
    logic [AW-1:0] pc_in;
    logic [AW-1:0] mar_in;

    // Incrementer and input multiplexers.
    always_comb begin
        pc_inc = pc + 1'b1;
        pc_in  = (ctl.pc_sel == SEL_EXTERNAL) ? branch_target : pc_inc;
        mar_in = (ctl.mar_sel == SEL_EXTERNAL) ? operand_addr : pc;
    end

    // Enabled register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            mar <= '0;
            mdr <= '0;
            ir  <= '0;
        end else begin
            if (ctl.pc)  pc  <= pc_in;
            if (ctl.mar) mar <= mar_in;
            if (ctl.mdr) mdr <= mem_rdata;
            if (ctl.ir)  ir  <= mdr;
        end
    end
endmodule

// File: rtl/fetch_mem.sv
// Behavioural word memory: synchronous write, combinational read.
// Assumes DEPTH = 2**AW words with no reset on the contents.
module fetch_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write the addressed word.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Read port follows the address.
    assign rd_data = store[rd_addr];
endmodule

// File: rtl/fetch_unit.sv
// Top level: sequencer, datapath and memory for the instruction fetch.
// Assumes the execute state is a one-cycle placeholder.
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] branch_target,
    input  logic [AW-1:0] operand_addr,
    input  logic          mem_wr_en,
    input  logic [AW-1:0] mem_wr_addr,
    input  logic [DW-1:0] mem_wr_data,
    output logic [1:0]    state_o,
    output logic          ld_mar_o,
    output logic          ld_mdr_o,
    output logic          ld_ir_o,
    output logic          ld_pc_o,
    output logic          mar_sel_o,
    output logic          pc_sel_o,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] mar_o,
    output logic [DW-1:0] mdr_o,
    output logic [DW-1:0] ir_o
);
    fetch_state_t  state;
    fetch_ctl_t    ctl;
    logic [DW-1:0] mem_rdata;

    fetch_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .ctl   (ctl)
    );

    fetch_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl           (ctl),
        .branch_target (branch_target),
        .operand_addr  (operand_addr),
        .mem_rdata     (mem_rdata),
        .pc            (pc_o),
        .mar           (mar_o),
        .mdr           (mdr_o),
        .ir            (ir_o)
    );

    fetch_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .wr_en   (mem_wr_en),
        .wr_addr (mem_wr_addr),
        .wr_data (mem_wr_data),
        .rd_addr (mar_o),
        .rd_data (mem_rdata)
    );

    // Bring the control outputs to the ports.
    always_comb begin
        state_o   = state;
        ld_mar_o  = ctl.mar;
        ld_mdr_o  = ctl.mdr;
        ld_ir_o   = ctl.ir;
        ld_pc_o   = ctl.pc;
        mar_sel_o = ctl.mar_sel;
        pc_sel_o  = ctl.pc_sel;
    end
endmodule

// File: rtl/fetch_unit_chk.sv
// Checker for fetch_unit: state order and register transfers across edges.
// Assumes reset is asserted from time zero.
module fetch_unit_chk #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    state_o,
    input logic          ld_mar_o,
    input logic          ld_mdr_o,
    input logic          ld_ir_o,
    input logic [AW-1:0] pc_o,
    input logic [AW-1:0] mar_o,
    input logic [DW-1:0] mdr_o,
    input logic [DW-1:0] ir_o
);
    AST_EXEC_TO_MAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> (state_o == 2'd1)); // R2
    AST_MAR_TO_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |=> (state_o == 2'd2)); // R2
    AST_MDR_TO_IR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (state_o == 2'd3)); // R2
    AST_MAR_GETS_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |=> (mar_o == $past(pc_o))); // R3
    AST_PC_STEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |=> (pc_o == $past(pc_o) + 1'b1)); // R4
    AST_IR_GETS_MDR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (ir_o == $past(mdr_o))); // R5
    AST_EXEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0) |=> ($stable(pc_o) && $stable(mar_o) && $stable(mdr_o) && $stable(ir_o))); // R6
    AST_ONE_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_mar_o, ld_mdr_o, ld_ir_o})); // R6
endmodule

bind fetch_unit fetch_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_o  (state_o),
    .ld_mar_o (ld_mar_o),
    .ld_mdr_o (ld_mdr_o),
    .ld_ir_o  (ld_ir_o),
    .pc_o     (pc_o),
    .mar_o    (mar_o),
    .mdr_o    (mdr_o),
    .ir_o     (ir_o)
);

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] branch_target = '0;
    logic [AW-1:0] operand_addr = '0;
    logic          mem_wr_en = 1'b0;
    logic [AW-1:0] mem_wr_addr = '0;
    logic [DW-1:0] mem_wr_data = '0;
    logic [1:0]    state_o;
    logic          ld_mar_o, ld_mdr_o, ld_ir_o, ld_pc_o, mar_sel_o, pc_sel_o;
    logic [AW-1:0] pc_o, mar_o;
    logic [DW-1:0] mdr_o, ir_o;

    int checks = 0;
    int failures = 0;
    bit cmp_en = 1'b0;

    // Behavioural reference model state.
    logic [1:0]    m_state;
    logic [AW-1:0] m_pc, m_mar;
    logic [DW-1:0] m_mdr, m_ir;
    logic [DW-1:0] m_mem [DEPTH];

    fetch_unit #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .branch_target(branch_target),
        .operand_addr(operand_addr), .mem_wr_en(mem_wr_en),
        .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .state_o(state_o), .ld_mar_o(ld_mar_o), .ld_mdr_o(ld_mdr_o),
        .ld_ir_o(ld_ir_o), .ld_pc_o(ld_pc_o), .mar_sel_o(mar_sel_o),
        .pc_sel_o(pc_sel_o), .pc_o(pc_o), .mar_o(mar_o), .mdr_o(mdr_o),
        .ir_o(ir_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] word_of(int i);
        return DW'((i * 467 + 1441) ^ (i * 512));
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model: advances one cycle per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 2'd0;
            m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0;
        end else begin
            case (m_state)
                2'd1: m_mar = m_pc;
                2'd2: begin m_mdr = m_mem[m_mar]; m_pc = m_pc + 1'b1; end
                2'd3: m_ir = m_mdr;
                default: ;
            endcase
            m_state = m_state + 2'd1;
        end
        if (mem_wr_en) m_mem[mem_wr_addr] = mem_wr_data;
    end

    // Compare the design against the model on every cycle.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk("R2", "state", 32'(state_o), 32'(m_state));
            chk("R3", "mar", 32'(mar_o), 32'(m_mar));
            chk("R4", "pc", 32'(pc_o), 32'(m_pc));
            chk("R9", "mdr", 32'(mdr_o), 32'(m_mdr));
            chk("R5", "ir", 32'(ir_o), 32'(m_ir));
            chk("R3", "ld_mar", 32'(ld_mar_o), 32'(m_state == 2'd1));
            chk("R4", "ld_mdr", 32'(ld_mdr_o), 32'(m_state == 2'd2));
            chk("R4", "ld_pc", 32'(ld_pc_o), 32'(m_state == 2'd2));
            chk("R5", "ld_ir", 32'(ld_ir_o), 32'(m_state == 2'd3));
            if (m_state == 2'd1) chk("R8", "mar_sel", 32'(mar_sel_o), 32'd0);
            if (m_state == 2'd2) chk("R8", "pc_sel", 32'(pc_sel_o), 32'd0);
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Run four cycles of one fetch with random external inputs (R8).
    task automatic one_fetch();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            branch_target = AW'($urandom);
            operand_addr = AW'($urandom);
        end
    endtask

    initial begin
        // Preload memory while reset is held (R9).
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            mem_wr_en = 1'b1;
            mem_wr_addr = AW'(i);
            mem_wr_data = word_of(i);
        end
        @(negedge clk);
        mem_wr_en = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset state", 32'(state_o), 32'd0);
        chk("R1", "reset pc", 32'(pc_o), 32'd0);
        chk("R1", "reset ir", 32'(ir_o), 32'd0);
        chk("R1", "reset loads", 32'({ld_mar_o, ld_mdr_o, ld_ir_o, ld_pc_o}), 32'd0);
        cmp_en = 1'b1;
        rst_n = 1'b1;
        // More fetches than words, so PC wraps (R7).
        for (int k = 0; k < DEPTH + 6; k++) begin
            one_fetch();
            chk("R5", "fetched word", 32'(ir_o), 32'(word_of(k % DEPTH)));
            chk("R7", "pc per fetch", 32'(pc_o), 32'((k + 1) % DEPTH));
        end
        // Reset in the middle of the data-load step.
        @(negedge clk);
        @(negedge clk);
        chk("R4", "in data-load", 32'(state_o), 32'd2);
        rst_n = 1'b0;
        mem_wr_en = 1'b1;
        mem_wr_addr = AW'(2);
        mem_wr_data = 16'hBEEF;
        @(negedge clk);
        mem_wr_en = 1'b0;
        chk("R1", "mid reset state", 32'(state_o), 32'd0);
        chk("R1", "mid reset pc", 32'(pc_o), 32'd0);
        chk("R1", "mid reset loads", 32'({ld_mar_o, ld_mdr_o, ld_ir_o, ld_pc_o}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            one_fetch();
            chk("R9", "refetch word", 32'(ir_o),
                32'((k == 2) ? 16'hBEEF : word_of(k)));
            chk("R4", "refetch pc", 32'(pc_o), 32'(k + 1));
        end
        // R6: execute state leaves registers unchanged.
        @(negedge clk);
        chk("R6", "exec ir hold", 32'(ir_o), 32'hBEEF);
        chk("R6", "exec pc hold", 32'(pc_o), 32'd3);
        cmp_en = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule